// File: doc/BRIEF.md
# Reconfigurable Shift-Add Constant Multiplier

This block multiplies a 16-bit signed sample by a 17-bit coded coefficient that can change on any clock cycle. It has no general array multiplier. The top coefficient bit is a sign flag, and the lower sixteen bits give the magnitude, inverted bitwise when the flag is set. The magnitude is cut into eight 2-bit slices. Each slice picks one of four precomputed multiples of the sample (0, x, 2x, 3x), which are built from shifts and one addition.

The eight picked terms are aligned to their slice weight, and their low-order bits are dropped. Lower slices lose more bits. The terms are then summed in a three-layer adder tree. An adder in that tree outputs zero when the coefficient nibble or byte feeding it is zero. The 16-bit result keeps the upper bits of the aligned sum and is negated when the sign flag is set. It is captured in an output register, which adds one cycle of latency.

Typical use is one tap of a filter whose coefficients are reloaded at run time. A new sample and coefficient pair may be presented every cycle.

Top module: `cmul_top`

## Requirements
- R1: The product for the sample and coefficient present at a rising clock edge appears on `prod` immediately after that edge and holds until the next edge. A new pair is accepted every cycle.
- R2: While `rst` is high at a rising edge, `prod` becomes 0.
- R3: Coefficient bit 16 is the sign flag. When it is 0, the magnitude M is coefficient bits 15:0. When it is 1, M is the bitwise inverse of bits 15:0.
- R4: For k = 0..7, slice k is M[2k+1:2k]. Its value 0, 1, 2 or 3 selects the multiple 0, x, 2x or 3x of the signed sample x.
- R5: Term k is floor(sel_k·x / 2^(15−2k)). Term 7 is 17 bits wide and term 0 is 3 bits wide, shrinking by two bits per slice.
- R6: With S the sum of the eight terms, the unsigned-sign result is floor(S/2), taken modulo 2^16.
- R7: When the sign flag is 1, `prod` is the two's-complement negation of the R6 result, modulo 2^16. For x = −32768 with M = 0x8000 the output is 0x4000.
- R8: Any coefficient whose magnitude has one or more zero nibbles still gives exactly the R4–R7 value.
- R9: Any coefficient whose magnitude has a zero byte still gives exactly the R4–R7 value.
- R10: A zero magnitude (coefficient 0x00000 or 0x1FFFF) or a zero sample gives `prod` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 16 | Signed input sample |
| coef | input | 17 | Coded coefficient: sign flag in bit 16, magnitude code in bits 15:0 |
| prod | output | 16 | Registered signed product |

## Verification
Every result is due exactly one rising edge after its pair is applied. The bench drives each pair on a falling edge and queues the expected value computed from R3–R7. A monitor pops and compares one queue entry 1 ns after each following rising edge. In back-to-back streams, result n is therefore never confused with result n+1. The reset checks sample at that same point after an edge taken with `rst` high.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
    localparam int XW    = 16;          // sample width
    localparam int MW    = 16;          // coefficient magnitude width
    localparam int CW    = MW + 1;      // coded coefficient width
    localparam int OW    = 16;          // product width
    localparam int NS    = MW / 2;      // number of 2-bit slices
    localparam int PW    = XW + 2;      // width of the 3x multiple
    localparam int SW    = XW + 3;      // adder tree working width

    typedef struct packed {
        logic [OW-1:0] prod;
    } cmul_state_t;
endpackage

// File: rtl/cmul_sign.sv
module cmul_sign #(
    parameter int MW = 16
) (
    input  logic [MW:0]   coef,
    output logic [MW-1:0] mag,
    output logic          neg
);
    always_comb begin
        neg = coef[MW];
        mag = coef[MW] ? ~coef[MW-1:0] : coef[MW-1:0];
    end
endmodule

// File: rtl/cmul_terms.sv
module cmul_terms #(
    parameter int XW = 16,
    parameter int MW = 16,
    parameter int SW = 19,
    localparam int NS = MW / 2,
    localparam int PW = XW + 2
) (
    input  logic signed [XW-1:0]        x,
    input  logic        [MW-1:0]        mag,
    output logic        [NS-1:0][SW-1:0] terms
);
    logic signed [PW-1:0] mul1, mul2, mul3;

    // Shared multiples: shifts plus a single adder.
    always_comb begin
        mul1 = PW'(x);
        mul2 = PW'(x) <<< 1;
        mul3 = mul1 + mul2;
    end

    for (genvar k = 0; k < NS; k++) begin : g_slice
        localparam int SH = (MW - 1) - 2 * k;   // bits dropped from term k
        localparam int TW = PW - SH;            // retained term width
        logic        [1:0]    sel;
        logic signed [PW-1:0] pick;
        logic signed [TW-1:0] trunc;

        always_comb begin
            sel = mag[2*k+1 -: 2];
            case (sel)
                2'd0:    pick = '0;
                2'd1:    pick = mul1;
                2'd2:    pick = mul2;
                default: pick = mul3;
            endcase
            trunc = pick[PW-1:SH];
            terms[k] = SW'(trunc);
        end
    end
endmodule

// File: rtl/cmul_tree.sv
module cmul_tree #(
    parameter int MW = 16,
    parameter int SW = 19,
    localparam int NS = MW / 2,
    localparam int NN = MW / 4,
    localparam int NB = MW / 8
) (
    input  logic [NS-1:0][SW-1:0] terms,
    input  logic [MW-1:0]         mag,
    output logic [SW-1:0]         sum
);
    logic [NN-1:0][SW-1:0] l2;
    logic [NB-1:0][SW-1:0] l3;
    logic [NN-1:0]         nib_on;
    logic [NB-1:0]         byte_on;

    // Control grouping: nibble and byte activity flags.
    for (genvar n = 0; n < NN; n++) begin : g_nib
        assign nib_on[n] = |mag[4*n+3 -: 4];
        always_comb begin
            l2[n] = nib_on[n] ? (terms[2*n] + terms[2*n+1]) : '0;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_on[b] = |mag[8*b+7 -: 8];
        always_comb begin
            l3[b] = byte_on[b] ? (l2[2*b] + l2[2*b+1]) : '0;
        end
    end

    assign sum = l3[0] + l3[1];
endmodule

// File: rtl/cmul_top.sv
module cmul_top
    import cmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x,
    input  logic [CW-1:0] coef,
    output logic [OW-1:0] prod
);
    logic [MW-1:0]         mag;
    logic                  neg;
    logic [NS-1:0][SW-1:0] terms;
    logic [SW-1:0]         sum;
    cmul_state_t           st_d, st_q;

    cmul_sign #(.MW(MW)) u_sign (
        .coef (coef),
        .mag  (mag),
        .neg  (neg)
    );

    cmul_terms #(.XW(XW), .MW(MW), .SW(SW)) u_terms (
        .x     (x),
        .mag   (mag),
        .terms (terms)
    );

    cmul_tree #(.MW(MW), .SW(SW)) u_tree (
        .terms (terms),
        .mag   (mag),
        .sum   (sum)
    );

    always_comb begin
        logic [OW-1:0] mag_prod;
        mag_prod = sum[OW:1];
        st_d      = st_q;
        st_d.prod = neg ? (~mag_prod + OW'(1)) : mag_prod;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prod = st_q.prod;
endmodule

// File: rtl/cmul_top_chk.sv
module cmul_top_chk
    import cmul_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [XW-1:0] x,
    input logic [CW-1:0] coef,
    input logic [OW-1:0] prod
);
    a_r2_reset_clears: assert property (@(posedge clk) rst |=> prod == '0);

    a_r10_zero_mag: assert property (@(posedge clk) disable iff (rst)
        (coef == 17'h00000 || coef == 17'h1FFFF) |=> prod == '0);

    a_r10_zero_x: assert property (@(posedge clk) disable iff (rst)
        (x == '0) |=> prod == '0);

    a_r4_top_slice: assert property (@(posedge clk) disable iff (rst)
        (coef == 17'h08000) |=> prod == OW'($signed($past(x)) >>> 1));

    a_r7_neg_top: assert property (@(posedge clk) disable iff (rst)
        (coef == 17'h17FFF) |=> prod == OW'(-($signed($past(x)) >>> 1)));
endmodule

bind cmul_top cmul_top_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .x    (x),
    .coef (coef),
    .prod (prod)
);

// File: tb/cmul_top_test.sv
module cmul_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] x = '0;
    logic [16:0] coef = '0;
    logic [15:0] prod;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    cmul_top uut (.clk(clk), .rst(rst), .x(x), .coef(coef), .prod(prod));

    always #10 clk = ~clk;

    function automatic logic [15:0] model(logic [15:0] xi, logic [16:0] ci);
        int xs, m, s, r;
        logic [15:0] mg;
        xs = int'($signed(xi));
        mg = ci[16] ? ~ci[15:0] : ci[15:0];
        s  = 0;
        for (int k = 0; k < 8; k++) begin
            m = int'(mg[2*k +: 2]) * xs;
            s = s + (m >>> (15 - 2*k));
        end
        r = s >>> 1;
        if (ci[16]) r = -r;
        return r[15:0];
    endfunction

    task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] xi, logic [16:0] ci, string tag);
        item_t it;
        @(negedge clk);
        x = xi;
        coef = ci;
        it.exp = model(xi, ci);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: each queued result is due one edge after it was driven.
    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(prod, it.exp, it.tag);
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        #1 check(prod, 16'h0000, "R2 reset");
        @(negedge clk) rst = 1'b0;

        drive(16'd1000, 17'h08000, "R4 top slice");
        drive(16'd1234, 17'h00000, "R10 zero coef");
        drive(16'h8123, 17'h1FFFF, "R10 inverted zero");
        drive(16'h0000, 17'h0BEEF, "R10 zero x");
        drive(16'd4000, 17'h0C000, "R4 slice 3x");
        drive(16'hF000, 17'h04000, "R4 negative x");
        drive(16'd300,  17'h0FFFF, "R5 full magnitude");
        drive(16'h7FFF, 17'h00003, "R5 lowest slice");
        drive(16'd777,  17'h1A5A5, "R3 inverted code");
        drive(16'd777,  17'h05A5A, "R3 plain code");
        drive(16'h8000, 17'h17FFF, "R7 wrap corner");
        drive(16'd2500, 17'h1F0FF, "R7 negative coef");
        drive(16'd9999, 17'h000F0, "R8 nibbles zero");
        drive(16'hC001, 17'h00F00, "R8 nibble only");
        drive(16'd5555, 17'h0F00F, "R8 middle nibbles");
        drive(16'd3210, 17'h000FF, "R9 high byte zero");
        drive(16'hA5A5, 17'h0FF00, "R9 low byte zero");
        drive(16'h7FFF, 17'h0FFFF, "R6 max positive");
        drive(16'h8000, 17'h0FFFF, "R6 max negative");
        drain();

        // Back-to-back stream, R1 latency under continuous input.
        lf = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            drive(lf[15:0], {lf[27], lf[31:16]}, "R1 stream");
        end
        drain();

        // Reset mid-operation clears the output.
        drive(16'd20000, 17'h0FFFF, "R1 before reset");
        drain();
        @(negedge clk) rst = 1'b1;
        @(posedge clk) #1 check(prod, 16'h0000, "R2 mid reset");
        @(negedge clk) rst = 1'b0;
        drive(16'd100, 17'h08000, "R1 after reset");
        drain();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule